// File: doc/BRIEF.md
# Majority-Logic Bit-Serial Adder with Zone Pipelining

This block adds two unsigned operands one bit per clock, least significant bit first, using a full-adder core that is built only from 3-input majority gates and inverters. Every gate level is followed by exactly one register stage, called a zone. Signals that have to wait for a deeper path are padded with plain register zones, so every majority gate sees all three of its inputs from the same zone. The carry leaves the core and comes back as the carry input of the next bit, which makes the one-bit adder a serial adder of any word length.

A word is presented as a run of valid bits. The first bit of every word carries a start flag, which makes that bit's carry input zero no matter what the previous word left behind. Cycles with the valid flag low are gaps. They may appear anywhere, including inside a word, and they leave the running carry untouched. Each valid input bit produces one valid output bit, the sum together with that bit's carry-out, a fixed number of zones later. The last carry-out of a word is the top bit of the word's sum. Words can follow one another with no idle cycle in between.

Top module: `maj_serial_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `out_sum` and `out_carry` are 0.
- R2: `out_valid` equals `in_valid` delayed by LATENCY = 6 + OUT_WIRE_ZONES clock cycles (7 with the default parameters).
- R3: For a valid bit with operand bits a and b and carry input ci, `out_sum` is a XOR b XOR ci, presented LATENCY cycles after the bit was presented.
- R4: `out_carry` is the majority of a, b and ci for the same bit, and it appears in the same cycle as that bit's sum.
- R5: A valid bit with `in_start` = 1 uses carry input 0, even if the previous word ended with a carry of 1.
- R6: For a valid bit with `in_start` = 0, the carry input is the carry-out of the most recent earlier valid bit, however many gap cycles lie between them.
- R7: A word of W bits (1 to 32), presented LSB first, gives out_sum bits that form (A + B) mod 2^W, LSB first, and the out_carry of its last bit is bit W of A + B.
- R8: `in_start`, `in_a` and `in_b` have no effect during a cycle with `in_valid` = 0.
- R9: Words may be presented back to back, with the start bit of one word in the cycle right after the last bit of the previous word, and every word still gives its own correct sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every zone register captures on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Operand A bit, LSB first |
| in_b | input | 1 | Operand B bit, LSB first |
| in_start | input | 1 | Marks the first bit of a word; counts only when in_valid is high |
| in_valid | input | 1 | High when in_a and in_b hold a bit of a word |
| out_sum | output | 1 | Sum bit, LATENCY cycles after its inputs |
| out_carry | output | 1 | Carry-out of the same bit, aligned with out_sum |
| out_valid | output | 1 | Marks a sum bit and carry bit that belong to a valid input bit |

## Verification
The assertions assume that reset is applied before the first valid bit. They also assume that the first valid bit after reset carries the start flag, because the carry register only has a defined meaning from that bit onward. The stimulus keeps to this: every word opens with a start-flagged bit, and both operand bits and the start flag are randomised during gap cycles, which exercises R8 without breaking that assumption. The stimulus covers words of random length between 1 and 32 bits, sent both back to back and with random gaps, along with directed cases in which a word that ends with a carry is followed at once by a new word.

// File: rtl/maj_serial_pkg.sv
package maj_serial_pkg;
  // Zones from input capture to the sum register, excluding extra output wiring
  localparam int CORE_ZONES = 6;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/maj_cell.sv
// One majority gate followed by its zone register. INV selects input inverters.
module maj_cell #(
  parameter logic [2:0] INV = 3'b000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic x,
  input  logic y,
  input  logic z,
  output logic q
);
  import maj_serial_pkg::*;

  logic gate_out;

  always_comb gate_out = maj3(x ^ INV[0], y ^ INV[1], z ^ INV[2]);

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= gate_out;
  end
endmodule

// File: rtl/zone_wire.sv
// A wire segment spanning DEPTH zones: DEPTH register stages, no logic.
module zone_wire #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_direct
      assign q = d;
    end else begin : g_stages
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/maj_serial_adder.sv
module maj_serial_adder #(
  parameter int OUT_WIRE_ZONES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  input  logic in_start,
  input  logic in_valid,
  output logic out_sum,
  output logic out_carry,
  output logic out_valid
);
  import maj_serial_pkg::*;

  localparam int LATENCY = CORE_ZONES + OUT_WIRE_ZONES;

  // Zone 1: capture, with the start flag inverted on the way in
  logic a1, b1, nsow1, v1;
  zone_wire #(.W(4), .DEPTH(1)) u_z1 (
    .clk(clk), .rst(rst),
    .d({in_a, in_b, ~in_start, in_valid}),
    .q({a1, b1, nsow1, v1})
  );

  // Zone 2: generate (AND) and propagate (OR) as majority gates with constants
  logic pa2, po2, a2, b2, nsow2, v2;
  maj_cell #(.INV(3'b000)) u_and2 (
    .clk(clk), .rst(rst), .en(1'b1), .x(a1), .y(b1), .z(1'b0), .q(pa2));
  maj_cell #(.INV(3'b000)) u_or2 (
    .clk(clk), .rst(rst), .en(1'b1), .x(a1), .y(b1), .z(1'b1), .q(po2));
  zone_wire #(.W(4), .DEPTH(1)) u_z2 (
    .clk(clk), .rst(rst),
    .d({a1, b1, nsow1, v1}),
    .q({a2, b2, nsow2, v2})
  );

  // Zone 3: q3 = start ? AND : OR (majority acts as a mux because AND <= OR)
  logic q3, pa3, a3, b3, nsow3, v3;
  maj_cell #(.INV(3'b000)) u_sel3 (
    .clk(clk), .rst(rst), .en(1'b1), .x(pa2), .y(po2), .z(nsow2), .q(q3));
  zone_wire #(.W(5), .DEPTH(1)) u_z3 (
    .clk(clk), .rst(rst),
    .d({pa2, a2, b2, nsow2, v2}),
    .q({pa3, a3, b3, nsow3, v3})
  );

  // Zone 4: carry loop (one gate, one zone) and the gated carry input
  logic carry_fb, cin4, a4, b4, v4;
  maj_cell #(.INV(3'b000)) u_carry4 (
    .clk(clk), .rst(rst), .en(v3), .x(pa3), .y(q3), .z(carry_fb), .q(carry_fb));
  maj_cell #(.INV(3'b000)) u_cin4 (
    .clk(clk), .rst(rst), .en(1'b1), .x(carry_fb), .y(nsow3), .z(1'b0), .q(cin4));
  zone_wire #(.W(3), .DEPTH(1)) u_z4 (
    .clk(clk), .rst(rst),
    .d({a3, b3, v3}),
    .q({a4, b4, v4})
  );

  // Zone 5: inner sum term MAJ(a, b, ~cin)
  logic t5, c5, cin5, v5;
  maj_cell #(.INV(3'b100)) u_inner5 (
    .clk(clk), .rst(rst), .en(1'b1), .x(a4), .y(b4), .z(cin4), .q(t5));
  zone_wire #(.W(3), .DEPTH(1)) u_z5 (
    .clk(clk), .rst(rst),
    .d({carry_fb, cin4, v4}),
    .q({c5, cin5, v5})
  );

  // Zone 6: sum = MAJ(~carry, cin, inner); carry padded to stay aligned
  logic s6, c6, v6;
  maj_cell #(.INV(3'b001)) u_sum6 (
    .clk(clk), .rst(rst), .en(1'b1), .x(c5), .y(cin5), .z(t5), .q(s6));
  zone_wire #(.W(2), .DEPTH(1)) u_z6 (
    .clk(clk), .rst(rst),
    .d({c5, v5}),
    .q({c6, v6})
  );

  // Output wiring zones
  zone_wire #(.W(3), .DEPTH(OUT_WIRE_ZONES)) u_zout (
    .clk(clk), .rst(rst),
    .d({s6, c6, v6}),
    .q({out_sum, out_carry, out_valid})
  );
endmodule

// File: rtl/maj_serial_adder_chk.sv
module maj_serial_adder_chk #(
  parameter int OUT_WIRE_ZONES = 1
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_sum,
  input logic out_carry,
  input logic carry_fb,
  input logic v3,
  input logic nsow3,
  input logic cin4
);
  import maj_serial_pkg::*;

  localparam int LAT = CORE_ZONES + OUT_WIRE_ZONES;
  localparam int CW  = $clog2(LAT + 1);

  logic [LAT-1:0] vshadow;
  logic [CW-1:0]  seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      vshadow <= '0;
      seen    <= '0;
    end else begin
      vshadow <= {vshadow[LAT-2:0], in_valid};
      if (seen < CW'(LAT)) seen <= seen + 1'b1;
    end
  end

  // R1: outputs are clear right after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_sum && !out_carry));

  // R2: valid flag leaves exactly LAT cycles after it entered
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (seen == CW'(LAT)) |-> (out_valid == vshadow[LAT-1]));

  // R5: a start-flagged valid bit sees carry input 0 in the next zone
  a_r5_start_clears_cin: assert property (@(posedge clk) disable iff (rst)
    (v3 && !nsow3) |=> !cin4);

  // R6 / R8: gap cycles leave the carry loop untouched
  a_r6_carry_holds_in_gap: assert property (@(posedge clk) disable iff (rst)
    !v3 |=> $stable(carry_fb));

  // R2: the valid output is never unknown after reset
  a_r2_valid_known: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(out_valid));
endmodule

bind maj_serial_adder maj_serial_adder_chk #(.OUT_WIRE_ZONES(OUT_WIRE_ZONES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sum(out_sum), .out_carry(out_carry),
  .carry_fb(carry_fb), .v3(v3), .nsow3(nsow3), .cin4(cin4)
);

// File: tb/test_maj_serial_adder.sv
module test_maj_serial_adder;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_start = 1'b0, in_valid = 1'b0;
  logic out_sum, out_carry, out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit     v;
    bit     s;
    bit     c;
    bit     last;
    int     w;
    longint wsum;
    string  tag;
  } exp_t;

  exp_t   eq[$];
  bit     model_carry = 1'b0;
  longint acc = 0;
  int     pos = 0;

  maj_serial_adder #(.OUT_WIRE_ZONES(1)) i_maj_serial_adder (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .in_start(in_start), .in_valid(in_valid),
    .out_sum(out_sum), .out_carry(out_carry), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Compare the current outputs with the oldest expectation, then drive one cycle.
  task automatic step(input bit a, input bit b, input bit st, input bit v,
                      input bit last, input int w, input longint wsum, input string tag);
    exp_t e, n;
    bit ci;
    @(negedge clk);
    e = eq.pop_front();
    check(out_valid == e.v, "R2", out_valid, e.v);
    if (e.v) begin
      check(out_sum == e.s, "R3", out_sum, e.s);
      check(out_carry == e.c, "R4", out_carry, e.c);
      acc = acc | (longint'(out_sum) << pos);
      pos++;
      if (e.last) begin
        longint got;
        got = acc | (longint'(out_carry) << e.w);
        check(got == e.wsum, e.tag, got, e.wsum);
        acc = 0;
        pos = 0;
      end
    end
    in_a = a; in_b = b; in_start = st; in_valid = v;
    n = '{v: v, s: 1'b0, c: 1'b0, last: last, w: w, wsum: wsum, tag: tag};
    if (v) begin
      ci = st ? 1'b0 : model_carry;
      n.s = a ^ b ^ ci;
      n.c = (a & b) | (a & ci) | (b & ci);
      model_carry = n.c;
    end
    eq.push_back(n);
  endtask

  // Send one word LSB first; gap_pct sets the chance of idle cycles before each bit.
  task automatic send_word(input int w, input longint A, input longint B,
                           input int gap_pct, input string tag);
    longint total;
    total = A + B;
    for (int i = 0; i < w; i++) begin
      while ($urandom_range(99) < gap_pct)
        step($urandom_range(1), $urandom_range(1), $urandom_range(1), 1'b0, 1'b0, 0, 0, "R8");
      step(((A >> i) & 1) != 0, ((B >> i) & 1) != 0, i == 0, 1'b1, i == w - 1, w, total, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!out_valid && !out_sum && !out_carry, "R1",
          {out_valid, out_sum, out_carry}, 0);
    rst = 1'b0;
    for (int k = 0; k < LAT; k++)
      eq.push_back('{v: 1'b0, s: 1'b0, c: 1'b0, last: 1'b0, w: 0, wsum: 0, tag: "R1"});
    @(posedge clk);
    #1;
    check(!out_valid && !out_sum && !out_carry, "R1",
          {out_valid, out_sum, out_carry}, 0);

    // R5: word ending with carry, then a zero word right after
    send_word(4, 64'hF, 64'h1, 0, "R5");
    send_word(3, 64'h0, 64'h0, 0, "R5");
    send_word(1, 64'h1, 64'h1, 0, "R5");
    send_word(1, 64'h0, 64'h1, 0, "R5");
    // R6 and R8: gaps inside a word with random start and operands during gaps
    send_word(8, 64'hFF, 64'h01, 60, "R6");
    send_word(16, 64'hBEEF, 64'h4111, 40, "R8");
    // R7: full-width extremes
    send_word(32, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, "R7");
    send_word(32, 64'h8000_0000, 64'h8000_0000, 10, "R7");
    // R9: back-to-back random words, then R7 random with gaps
    for (int k = 0; k < 40; k++) begin
      int w;
      longint A, B;
      w = $urandom_range(32, 1);
      A = longint'($urandom()) & ((longint'(1) << w) - 1);
      B = longint'($urandom()) & ((longint'(1) << w) - 1);
      send_word(w, A, B, 0, "R9");
    end
    for (int k = 0; k < 40; k++) begin
      int w;
      longint A, B;
      w = $urandom_range(32, 1);
      A = longint'($urandom()) & ((longint'(1) << w) - 1);
      B = longint'($urandom()) & ((longint'(1) << w) - 1);
      send_word(w, A, B, 25, "R7");
    end
    for (int k = 0; k < LAT + 2; k++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R2");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule